// File: doc/BRIEF.md
# Arithmetic Status Byte with Flag Generation

This block keeps an 8-bit status byte for a byte-wide processor datapath and produces the arithmetic result and condition flags for three operations on an accumulator value and a second operand: plain addition, addition that folds in the stored carry, and subtraction that folds in the stored carry as a borrow. The 8-bit result is combinational. When an operation is issued, the carry, half-carry and signed-overflow flags it produces are written into the status byte at the next clock edge.

The parity bit follows the accumulator on every clock edge, whether or not an operation is issued. Software may replace the whole byte or change one bit at a time. Two bits of the byte are also driven out as a register-bank selector for the surrounding core.

Top module: `sfu_top`

## Requirements
- R1: While reset is asserted, and at the first sample after it, the status byte reads 00H and the bank selector reads 0.
- R2: `result` is combinational. aluOp 0 gives acc+opnd, aluOp 1 gives acc+opnd+C, and aluOp 2 gives acc-opnd-C, each modulo 256. C is status bit 7. aluOp 3 gives acc unchanged.
- R3: An issued operation with aluOp 0 to 2 writes status bit 7 (carry). It is set on a carry out of bit 7 of the sum (an unsigned total above 255, for example 260), or on a borrow in subtraction.
- R4: An issued operation writes status bit 6 (half-carry). It is set on a carry out of the low nibble in addition, or on a borrow into the low nibble in subtraction.
- R5: An issued operation writes status bit 2 (overflow). It is set when the result lies outside -128..127 under two's-complement reading, counting the incoming carry or borrow.
- R6: Status bit 0 equals the XOR of all accIn bits sampled at the previous clock edge, so it is 1 for an odd count of ones. Software writes never change it.
- R7: wrByte loads wrData bits 7..1 into status bits 7..1. The layout is: bit 7 carry, 6 half-carry, 5 spare flag, 4 bank high, 3 bank low, 2 overflow, 1 user flag.
- R8: wrBit loads bitVal into status bit bitSel and leaves every other bit unchanged. bitSel 0 has no effect.
- R9: Priority is byte write, then bit write, then operation. An operation changes only bits 7, 6 and 2.
- R10: aluOp 3, or opValid low, leaves status bits 7..1 unchanged.
- R11: bankSel equals status bits {4,3}. It changes only after a byte or bit write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accIn | input | 8 | Accumulator value |
| operand | input | 8 | Second operand |
| aluOp | input | 2 | 0 add, 1 add with carry, 2 subtract with borrow, 3 none |
| opValid | input | 1 | Issue the operation; its flags are stored at the edge |
| result | output | 8 | Arithmetic result |
| wrByte | input | 1 | Write the whole status byte |
| wrData | input | 8 | Data for the byte write |
| wrBit | input | 1 | Write a single status bit |
| bitSel | input | 3 | Index of the bit to write |
| bitVal | input | 1 | Value for the bit write |
| statusWord | output | 8 | Status byte |
| bankSel | output | 2 | Register-bank selector |

## Verification
Additions are run with operand pairs chosen to separate the flags from one another:
- an unsigned wrap that is also a signed overflow, for example 84H+80H;
- a nibble-only carry, 0FH+01H;
- a signed-only overflow, 7FH+01H.

The carry-chained operations are run both with the stored carry set and with it clear, so that a missing carry-in shows up in the result. Subtractions cover a plain borrow and the 80H-00H-1 case, which sets the half-borrow and overflow flags without setting carry. Further cases write a byte or a bit in the same cycle as an issued operation, write to the parity position, and issue the null operation, to confirm the priority and that nothing changes when nothing should.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int IDX_W  = $clog2(DATA_W);

  localparam int CY_BIT  = 7;
  localparam int AC_BIT  = 6;
  localparam int F0_BIT  = 5;
  localparam int BKH_BIT = 4;
  localparam int BKL_BIT = 3;
  localparam int OV_BIT  = 2;
  localparam int UF_BIT  = 1;
  localparam int P_BIT   = 0;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_ADDC = 2'd1,
    OP_SUBB = 2'd2,
    OP_NONE = 2'd3
  } aluOp_e;

  typedef struct packed {
    logic loadByte;
    logic loadBit;
    logic loadArith;
  } strobe_t;
endpackage

// File: rtl/sfu_ctrl.sv
module sfu_ctrl
  import sfu_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    opValid,
  input  aluOp_e  aluOp,
  input  logic    wrByte,
  input  logic    wrBit,
  output strobe_t strobes
);
  always_comb begin
    strobes.loadByte  = wrByte;
    strobes.loadBit   = wrBit && !wrByte;
    strobes.loadArith = opValid && (aluOp != OP_NONE) && !wrByte && !wrBit;
  end

  // R9: at most one source updates the byte in any cycle
  assert_one_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadByte, strobes.loadBit, strobes.loadArith}));

  // R10: the null operation never raises the arithmetic strobe
  assert_null_op_R10: assert property (@(posedge clk) disable iff (!rstN)
    (aluOp == OP_NONE) |-> !strobes.loadArith);
endmodule

// File: rtl/sfu_dpath.sv
module sfu_dpath
  import sfu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  aluOp_e            aluOp,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  bitSel,
  input  logic              bitVal,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] statusWord
);
  logic [DATA_W-1:0] swReg, swNext;
  logic [DATA_W:0]   wide;
  logic [NIB_W:0]    low;
  logic              carryIn, cyOut, acOut, ovOut;

  always_comb begin
    carryIn = ((aluOp == OP_ADDC) || (aluOp == OP_SUBB)) ? swReg[CY_BIT] : 1'b0;
    wide = '0;
    low  = '0;
    ovOut = 1'b0;
    result = accIn;
    if (aluOp == OP_SUBB) begin
      wide = {1'b0, accIn} - {1'b0, operand} - {{DATA_W{1'b0}}, carryIn};
      low  = {1'b0, accIn[NIB_W-1:0]} - {1'b0, operand[NIB_W-1:0]}
             - {{NIB_W{1'b0}}, carryIn};
      result = wide[DATA_W-1:0];
      ovOut = (accIn[DATA_W-1] != operand[DATA_W-1]) &&
              (result[DATA_W-1] != accIn[DATA_W-1]);
    end else if (aluOp != OP_NONE) begin
      wide = {1'b0, accIn} + {1'b0, operand} + {{DATA_W{1'b0}}, carryIn};
      low  = {1'b0, accIn[NIB_W-1:0]} + {1'b0, operand[NIB_W-1:0]}
             + {{NIB_W{1'b0}}, carryIn};
      result = wide[DATA_W-1:0];
      ovOut = (accIn[DATA_W-1] == operand[DATA_W-1]) &&
              (result[DATA_W-1] != accIn[DATA_W-1]);
    end
    cyOut = wide[DATA_W];
    acOut = low[NIB_W];
  end

  always_comb begin
    swNext = swReg;
    if (strobes.loadByte) begin
      swNext[DATA_W-1:1] = wrData[DATA_W-1:1];
    end else if (strobes.loadBit) begin
      if (bitSel != IDX_W'(P_BIT)) swNext[bitSel] = bitVal;
    end else if (strobes.loadArith) begin
      swNext[CY_BIT] = cyOut;
      swNext[AC_BIT] = acOut;
      swNext[OV_BIT] = ovOut;
    end
    swNext[P_BIT] = ^accIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) swReg <= '0;
    else       swReg <= swNext;
  end

  assign statusWord = swReg;

  // R9: an operation leaves the control and user bits alone
  assert_arith_keeps_ctrl_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadArith |=> ($stable(statusWord[F0_BIT]) && $stable(statusWord[BKH_BIT]) &&
                           $stable(statusWord[BKL_BIT]) && $stable(statusWord[UF_BIT])));

  // R8: a single-bit write lands on the selected bit
  assert_bit_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadBit && bitSel != IDX_W'(P_BIT)) |=> statusWord[$past(bitSel)] == $past(bitVal));

  // R5: two positives giving a negative sum must raise overflow
  assert_ov_add_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadArith && aluOp == OP_ADD && !accIn[DATA_W-1] && !operand[DATA_W-1] &&
     result[DATA_W-1]) |=> statusWord[OV_BIT]);

  // R3: an add whose result is below the accumulator wrapped, so carry is set
  assert_carry_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadArith && aluOp == OP_ADD && result < accIn) |=> statusWord[CY_BIT]);
endmodule

// File: rtl/sfu_top.sv
module sfu_top
  import sfu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] accIn,
  input  logic [7:0] operand,
  input  logic [1:0] aluOp,
  input  logic       opValid,
  output logic [7:0] result,
  input  logic       wrByte,
  input  logic [7:0] wrData,
  input  logic       wrBit,
  input  logic [2:0] bitSel,
  input  logic       bitVal,
  output logic [7:0] statusWord,
  output logic [1:0] bankSel
);
  strobe_t strobes;
  aluOp_e  opCode;

  assign opCode = aluOp_e'(aluOp);

  sfu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .aluOp(opCode),
    .wrByte(wrByte), .wrBit(wrBit), .strobes(strobes)
  );

  sfu_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .aluOp(opCode),
    .accIn(accIn), .operand(operand), .wrData(wrData), .bitSel(bitSel),
    .bitVal(bitVal), .result(result), .statusWord(statusWord)
  );

  assign bankSel = statusWord[BKH_BIT:BKL_BIT];

  // R6: parity follows the accumulator seen at the previous edge
  assert_parity_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> statusWord[P_BIT] == ^$past(accIn));

  // R11: without a software write the bank selector holds
  assert_bank_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!wrByte && !wrBit) |=> $stable(bankSel));
endmodule

// File: tb/sim_sfu_top.sv
module sim_sfu_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] accIn = '0, operand = '0, wrData = '0;
  logic [1:0] aluOp = 2'd3;
  logic opValid = 0, wrByte = 0, wrBit = 0, bitVal = 0;
  logic [2:0] bitSel = '0;
  logic [7:0] result, statusWord;
  logic [1:0] bankSel;

  int checks = 0, failures = 0;
  logic [7:0] swM = '0;
  logic [7:0] expQ[$];
  string tagQ[$];
  bit done = 0;

  always #10 clk = ~clk;

  sfu_top u0 (.clk(clk), .rstN(rstN), .accIn(accIn), .operand(operand), .aluOp(aluOp),
    .opValid(opValid), .result(result), .wrByte(wrByte), .wrData(wrData), .wrBit(wrBit),
    .bitSel(bitSel), .bitVal(bitVal), .statusWord(statusWord), .bankSel(bankSel));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic int sgn(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  task automatic step(input int op, input bit vld, input int a, input int b,
                      input bit wb, input int wd, input bit wbt, input int bs,
                      input bit bv, input string tag);
    int c, full, lowv, s;
    logic [7:0] expRes, nxt;
    bit cy, ac, ov;
    @(negedge clk);
    accIn = 8'(a); operand = 8'(b); aluOp = 2'(op); opValid = vld;
    wrByte = wb; wrData = 8'(wd); wrBit = wbt; bitSel = 3'(bs); bitVal = bv;
    c = (op == 1 || op == 2) ? int'(swM[7]) : 0;
    if (op == 2) begin
      full = a - b - c; lowv = (a % 16) - (b % 16) - c; s = sgn(a) - sgn(b) - c;
      cy = full < 0; ac = lowv < 0;
    end else begin
      full = a + b + c; lowv = (a % 16) + (b % 16) + c; s = sgn(a) + sgn(b) + c;
      cy = full > 255; ac = lowv > 15;
    end
    ov = (s > 127) || (s < -128);
    expRes = (op == 3) ? 8'(a) : 8'(full);
    #2 chk({tag, " R2 result"}, result, expRes);
    nxt = swM;
    if (wb) nxt[7:1] = wd[7:1];
    else if (wbt) begin
      if (bs != 0) nxt[bs] = bv;
    end else if (vld && op != 3) begin
      nxt[7] = cy; nxt[6] = ac; nxt[2] = ov;
    end
    nxt[0] = ^(8'(a));
    swM = nxt;
    @(posedge clk);
    #1;
    expQ.push_back(nxt);
    tagQ.push_back(tag);
  endtask

  // monitor: compare stored byte and bank selector against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk({t, " status"}, statusWord, e);
        chk({t, " R11 bank"}, {6'd0, bankSel}, {6'd0, e[4:3]});
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    accIn = 8'h37;
    repeat (3) @(posedge clk);
    #1 chk("R1 reset status", statusWord, 8'h00);
    chk("R1 reset bank", {6'd0, bankSel}, 8'h00);
    @(negedge clk); rstN = 1'b1; accIn = 8'h00;
    #1 chk("R1 after release", statusWord, 8'h00);
    step(0, 1, 'h84, 'h80, 0, 0, 0, 0, 0, "R3 R5 unsigned wrap 260");
    step(0, 1, 'h0F, 'h01, 0, 0, 0, 0, 0, "R4 nibble carry");
    step(0, 1, 'h7F, 'h01, 0, 0, 0, 0, 0, "R5 signed overflow");
    step(0, 1, 'hFF, 'h01, 0, 0, 0, 0, 0, "R3 carry set");
    step(1, 1, 'h10, 'h20, 0, 0, 0, 0, 0, "R2 addc carry in");
    step(1, 1, 'h10, 'h20, 0, 0, 0, 0, 0, "R2 addc no carry");
    step(2, 1, 'h10, 'h20, 0, 0, 0, 0, 0, "R3 subb borrow");
    step(2, 1, 'h80, 'h00, 0, 0, 0, 0, 0, "R5 subb with borrow in");
    step(2, 1, 'h05, 'h03, 0, 0, 0, 0, 0, "R4 subb clean");
    step(3, 1, 'h5A, 'h33, 0, 0, 0, 0, 0, "R10 null op");
    step(0, 0, 'hFF, 'hFF, 0, 0, 0, 0, 0, "R10 not issued");
    step(3, 0, 'h01, 'h00, 1, 'hFF, 0, 0, 0, "R7 byte write");
    step(3, 0, 'h03, 'h00, 0, 0, 1, 4, 0, "R8 bit write bank");
    step(3, 0, 'h00, 'h00, 0, 0, 1, 0, 1, "R6 R8 parity not writable");
    step(0, 1, 'h01, 'h01, 0, 0, 0, 0, 0, "R9 op keeps ctrl bits");
    step(0, 1, 'hFF, 'h01, 1, 'h00, 0, 0, 0, "R9 byte beats op");
    step(0, 1, 'hFF, 'h01, 0, 0, 1, 1, 1, "R9 bit beats op");
    step(3, 0, 'h10, 'h00, 1, 'h18, 0, 0, 0, "R11 bank three");
    step(2, 1, 'h00, 'h01, 0, 0, 0, 0, 0, "R11 op keeps bank");
    step(3, 0, 'h07, 'h00, 0, 0, 0, 0, 0, "R6 parity odd");
    repeat (3) @(posedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule